// File: doc/BRIEF.md
# Seven-to-one multi-lane video link deserializer

The block turns a serial display link back into parallel pixel data. The link has one forwarded clock lane and up to four data lanes. Each lane carries seven bits in every link clock period. The block runs on a sampling clock at the bit rate, so it sees one sample per bit time on every lane and on the clock lane. It uses the high/low shape of the clock lane to find where each seven-bit group starts. It then sorts the lane bits into red, green and blue colour fields, two sync signals, a data enable and one spare control bit.

The parameter `FULL` picks the width. With `FULL=1` there are four lanes, 24-bit colour and a spare bit. With `FULL=0` there are three lanes and 18-bit colour. The block gives out a recovered pixel clock together with the data. New data appears on the same sampling edge where that pixel clock falls.

Data is held until framing has been confirmed. Data is also held when the link clock stops or the power-down input `pwr_n` is driven low.

Top module: `vlink_deser7`

## Requirements
- R1: The clock lane forms one period as seven samples: high for 4 samples, then low for 3. The sample where the clock lane is first high after being low is slot 0. Each data lane sends its bits most significant first, so slot s carries bit 6-s of that lane's 7-bit group.
- R2: With `FULL=1`, the lane groups (bit 6 down to 0) map to fields as follows:
  - lane 0 = {red[7:2], green[2]}
  - lane 1 = {green[7:3], blue[3:2]}
  - lane 2 = {blue[7:4], hsync, vsync, de}
  - lane 3 = {red[1:0], green[1:0], blue[1:0], spare}
- R3: With `FULL=0`, lane 3 is ignored. red[1:0], green[1:0], blue[1:0] and spare read 0. The other fields map as in R2.
- R4: While locked, the group received in period n appears on the outputs in period n+2. It is loaded on the sampling edge of slot 4 of that period.
- R5: The parallel outputs change only on a sampling edge where `pix_clk` goes from 1 to 0. While locked, `pix_clk` follows the clock lane one sample later.
- R6: `locked` rises on the slot-0 edge that ends the second consecutive correctly framed period. Outputs hold their value until then.
- R7: A period with the wrong length, or the wrong high/low pattern, clears `locked` at the next slot 0. Outputs then hold until relock per R6.
- R8: If the clock lane shows no new low-to-high edge for 7 samples after slot 0, `locked` clears. `pix_clk` and the outputs keep their last values. Relock follows R6.
- R9: While `pwr_n` is low, the next edge forces `locked` and `pix_clk` to 0, and the outputs hold. After release, relock follows R6.
- R10: After the asynchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| lclk_s | input | 1 | Sampled forwarded link clock lane |
| lane_d | input | 4 | Sampled data lanes; lane 3 is unused when `FULL=0` |
| pix_clk | output | 1 | Recovered pixel clock |
| locked | output | 1 | Framing confirmed |
| red | output | 8 | Red field |
| green | output | 8 | Green field |
| blue | output | 8 | Blue field |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| spare | output | 1 | Spare control bit |

## Verification
The bench sends each word with its least significant bits and the spare bit on lane 3. A design that swapped the bit order, or misplaced a lane, would show scrambled colours. The reduced-mode instance must show those same positions as zero.

It checks lock timing exactly, both at start-up and after each of the following:
- a malformed period;
- a stalled clock lane;
- a power-down in the middle of a period.

A design that locked after a single period, or leaked a stale word while relocking, would put the wrong value on the outputs before the third period.

It also samples the outputs on the slot before the pixel clock falls. This catches a design that launches data on the wrong edge or one cycle early.

// File: rtl/vlink_deser7.sv
module vlink_deser7 #(
  parameter int FULL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_n,
  input  logic       lclk_s,
  input  logic [3:0] lane_d,
  output logic       pix_clk,
  output logic       locked,
  output logic [7:0] red,
  output logic [7:0] green,
  output logic [7:0] blue,
  output logic       hsync,
  output logic       vsync,
  output logic       de,
  output logic       spare
);
  localparam int NL   = (FULL != 0) ? 4 : 3;
  localparam int WW   = NL * 7;
  localparam int SLOTS = 7;
  localparam int HIGHS = 4;

  logic              prev_c;
  logic [3:0]        cnt_q;
  logic              err_q;
  logic [1:0]        good_q, good_n;
  logic [NL-1:0][6:0] sh;
  logic [WW-1:0]     h1, h2, ow;

  wire        rise  = lclk_s & ~prev_c;
  wire [3:0]  idx   = rise ? 4'd0 : cnt_q;
  wire        inper = idx < 4'(SLOTS);
  wire        miss  = inper && (lclk_s != (idx < 4'(HIGHS)));
  wire        ok_pr = (cnt_q == 4'(SLOTS)) && !err_q;
  wire        upd   = locked && (idx == 4'(HIGHS)) && !lclk_s;

  always_comb begin
    good_n = good_q;
    if (rise) good_n = ok_pr ? ((good_q == 2'd2) ? 2'd2 : good_q + 2'd1) : 2'd0;
    else if (!inper) good_n = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c  <= 1'b0;
      cnt_q   <= 4'hf;
      err_q   <= 1'b0;
      good_q  <= 2'd0;
      locked  <= 1'b0;
      pix_clk <= 1'b0;
      sh      <= '0;
      h1      <= '0;
      h2      <= '0;
      ow      <= '0;
    end else if (!pwr_n) begin
      prev_c  <= 1'b0;
      cnt_q   <= 4'hf;
      err_q   <= 1'b0;
      good_q  <= 2'd0;
      locked  <= 1'b0;
      pix_clk <= 1'b0;
    end else begin
      prev_c  <= lclk_s;
      cnt_q   <= (idx == 4'hf) ? 4'hf : idx + 4'd1;
      err_q   <= rise ? 1'b0 : (err_q | miss);
      good_q  <= good_n;
      locked  <= (good_n == 2'd2);
      pix_clk <= locked ? lclk_s : pix_clk;
      for (int l = 0; l < NL; l++) sh[l] <= {sh[l][5:0], lane_d[l]};
      if (rise && ok_pr) begin
        h1 <= sh;
        h2 <= h1;
      end
      if (upd) ow <= h2;
    end
  end

  wire [6:0] w0 = ow[6:0];
  wire [6:0] w1 = ow[13:7];
  wire [6:0] w2 = ow[20:14];
  logic [6:0] w3;

  generate
    if (FULL != 0) begin : g_full
      assign w3 = ow[WW-1:21];
    end else begin : g_red
      assign w3 = 7'd0;
    end
  endgenerate

  assign red   = {w0[6:1], w3[6:5]};
  assign green = {w1[6:2], w0[0], w3[4:3]};
  assign blue  = {w2[6:3], w1[1:0], w3[2:1]};
  assign hsync = w2[2];
  assign vsync = w2[1];
  assign de    = w2[0];
  assign spare = w3[0];
endmodule

module vlink_deser7_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_n,
  input logic       lclk_s,
  input logic       pix_clk,
  input logic       locked,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic       hsync,
  input logic       vsync,
  input logic       de,
  input logic       spare
);
  wire [27:0] vid = {red, green, blue, hsync, vsync, de, spare};

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vid) |-> $fell(pix_clk));                                   // R5
  AST_HOLD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(vid));                                           // R6
  AST_LOCK_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(lclk_s) && !$past(lclk_s, 2)));             // R6
  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (!locked && !pix_clk));                                   // R9
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> $stable(vid));                                            // R9
endmodule

bind vlink_deser7 vlink_deser7_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lclk_s(lclk_s),
  .pix_clk(pix_clk), .locked(locked), .red(red), .green(green), .blue(blue),
  .hsync(hsync), .vsync(vsync), .de(de), .spare(spare)
);

// File: tb/vlink_deser7_tb_top.sv
module vlink_deser7_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1, lclk_s = 1'b0;
  logic [3:0] lane_d = 4'd0;
  logic pc_f, lk_f, hs_f, vs_f, de_f, sp_f, pc_r, lk_r, hs_r, vs_r, de_r, sp_r;
  logic [7:0] r_f, g_f, b_f, r_r, g_r, b_r;
  int errs = 0, checks = 0;
  logic [27:0] shown = '0;

  // entry layout: {red, green, blue, hsync, vsync, de, spare}
  localparam logic [27:0] VEC [8] = '{28'h0000000, 28'hFFFFFFF, 28'hAAAAAAA, 28'h5555555,
                                     28'h123456B, 28'hFEDCBA4, 28'h0F0F0F3, 28'h8137E5D};

  always #2 clk = ~clk;

  vlink_deser7 #(.FULL(1)) dut_i (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lclk_s(lclk_s),
    .lane_d(lane_d), .pix_clk(pc_f), .locked(lk_f), .red(r_f), .green(g_f), .blue(b_f),
    .hsync(hs_f), .vsync(vs_f), .de(de_f), .spare(sp_f));
  vlink_deser7 #(.FULL(0)) dut_r (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lclk_s(lclk_s),
    .lane_d(lane_d), .pix_clk(pc_r), .locked(lk_r), .red(r_r), .green(g_r), .blue(b_r),
    .hsync(hs_r), .vsync(vs_r), .de(de_r), .spare(sp_r));

  function automatic logic [27:0] got_f();
    return {r_f, g_f, b_f, hs_f, vs_f, de_f, sp_f};
  endfunction
  function automatic logic [27:0] got_r();
    return {r_r, g_r, b_r, hs_r, vs_r, de_r, sp_r};
  endfunction
  function automatic logic [27:0] red18(logic [27:0] e);
    return {e[27:22], 2'b0, e[19:14], 2'b0, e[11:6], 2'b0, e[3:1], 1'b0};
  endfunction
  function automatic logic [27:0] to_lanes(logic [27:0] e);
    logic [7:0] r, g, b;
    r = e[27:20]; g = e[19:12]; b = e[11:4];
    return {r[1:0], g[1:0], b[1:0], e[0],
            b[7:4], e[3], e[2], e[1],
            g[7:3], b[3:2],
            r[7:2], g[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit c, input logic [3:0] d);
    @(negedge clk);
    lclk_s = c;
    lane_d = d;
    @(posedge clk);
    #1;
  endtask

  task automatic send_run(input int n, input int base, input string hold_req);
    for (int k = 0; k < n; k++) begin
      logic [27:0] ln;
      ln = to_lanes(VEC[(base + k) % 8]);
      for (int s = 0; s < 7; s++) begin
        drive(s < 4, {ln[27-s], ln[20-s], ln[13-s], ln[6-s]});
        if (s == 0) begin
          chk(lk_f == (k >= 2), "R6 full", 28'(lk_f), 28'(k >= 2));
          chk(lk_r == (k >= 2), "R6 reduced", 28'(lk_r), 28'(k >= 2));
        end
        if (s == 3 && k >= 2) begin
          chk(pc_f == 1'b1, "R5 clk high", 28'(pc_f), 28'd1);
          chk(got_f() == shown, "R5 no early launch", got_f(), shown);
        end
        if (s == 4) begin
          if (k >= 2) begin
            shown = VEC[(base + k - 2) % 8];
            chk(got_f() == shown, "R1 R2 R4 data", got_f(), shown);
            chk(got_r() == red18(shown), "R3 reduced data", got_r(), red18(shown));
            chk(pc_f == 1'b0, "R5 clk fell", 28'(pc_f), 28'd0);
          end else begin
            chk(got_f() == shown, hold_req, got_f(), shown);
            chk(got_r() == red18(shown), hold_req, got_r(), red18(shown));
          end
        end
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({pc_f, lk_f} == 2'b00 && got_f() == '0, "R10 reset", got_f(), '0);
    chk({pc_r, lk_r} == 2'b00 && got_r() == '0, "R10 reset reduced", got_r(), '0);
    @(negedge clk);
    rst_n = 1'b1;
    send_run(16, 0, "R10 hold before lock");

    // R7: clock lane high for five samples
    for (int s = 0; s < 7; s++) drive(s < 5, 4'hF);
    send_run(6, 3, "R7 hold after bad frame");

    // R8: clock lane stops low
    for (int s = 0; s < 12; s++) drive(1'b0, 4'h5);
    chk(lk_f == 1'b0, "R8 lock lost", 28'(lk_f), 28'd0);
    chk(pc_f == 1'b0, "R8 clock held", 28'(pc_f), 28'd0);
    chk(got_f() == shown, "R8 data held", got_f(), shown);
    send_run(5, 5, "R8 hold after stall");

    // R9: power-down in the middle of a period
    drive(1'b1, 4'h0);
    drive(1'b1, 4'h0);
    chk(pc_f == 1'b1, "R9 clock high before power-down", 28'(pc_f), 28'd1);
    @(negedge clk);
    pwr_n = 1'b0;
    for (int s = 2; s < 21; s++) drive((s % 7) < 4, 4'hA);
    chk(lk_f == 1'b0 && lk_r == 1'b0, "R9 unlocked", 28'(lk_f), 28'd0);
    chk(pc_f == 1'b0, "R9 clock idle", 28'(pc_f), 28'd0);
    chk(got_f() == shown, "R9 data held", got_f(), shown);
    @(negedge clk);
    pwr_n = 1'b1;
    send_run(5, 1, "R9 hold after release");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule